// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Period-Aligned Update Buffers

This block generates four independent pulse-width modulated outputs, programmed through a simple register bus. The bus has an address, write data, a write strobe, a read strobe and read data. A small global window starts and stops channels with write-one-to-set and write-one-to-clear registers. It also reports which channels are running, and holds a set of sticky end-of-period flags that clear when read.

Each channel owns a 32-byte register window. The window holds a mode word (clock divider select, output polarity, update routing), the active duty and period values, and two shadow update registers. While a channel is stopped, software writes the active duty and period directly. While it runs, software writes the shadow registers instead. The hardware copies a staged value into the active register only when the counter wraps, so a period in flight is never cut short or stretched. The end-of-period flag lets software see that the hand-over has happened, for example before it stops a channel.

The duty value counts divided ticks during which the output sits at its inactive level. The output spends the remainder of the period at its active level.

Top module: `pwm_quad_buffered`

## Requirements
- R1: After reset every channel is stopped, every register reads zero and every output is low.
- R2: Writing to address 0x04 starts channel n for each bit n written as 1. Writing to 0x08 stops channel n for each bit n written as 1. Bits written as 0 change nothing. Reading 0x0C returns the running state of channel n in bit n.
- R3: A running channel counts divided ticks from 0 up to period-1 and then wraps to 0. With polarity 0 the output is low while the count is below the duty value and high otherwise, so each period contains (period - duty) high ticks. A period of 0 behaves as 1, and a duty at or above the period keeps the output low for the whole period.
- R4: Mode bits 3:0 select a divider of 2^sel input clocks per tick. Values above 10 act as 10.
- R5: Mode bit 9 set to 1 inverts the output. A stopped channel drives the level given by bit 9 and restarts its count from 0 when started again.
- R6: Writes to the duty register (channel offset 0x04) and the period register (offset 0x0C) take effect at once while the channel is stopped. They are ignored while the channel runs.
- R7: Offset 0x08 stages a new duty value. Offset 0x10 stages a new duty value when mode bit 10 is 0 and a new period value when it is 1. A staged value is copied into the active register only on the cycle the counter wraps. Until then the active register reads back unchanged, and offsets 0x08 and 0x10 read back the staged duty and period values.
- R8: At address 0x1C, bit n is set each time channel n wraps. A read returns the flags and clears them, except for a flag raised in the same cycle as the read, which is kept.
- R9: Channel n's window starts at 0x200 + n*0x20. Only the low 16 bits of the mode, duty, period and update registers are stored, and the upper bits read as zero. Read data appears on the clock after the read strobe, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| pwm_out | output | 4 | Registered PWM outputs, one per channel |

## Verification
On every cycle the assertions check four things: the counter stays below the effective period; active duty and period never move while a channel runs except on a wrap; a wrap with a staged value loads exactly that value; and a stopped channel drives its polarity level. They also check that start and stop writes land in the running state and that a flag read with no concurrent wrap leaves the flags empty. The bench scenarios cover what a single cycle cannot show: high-time ratios over whole periods at several divider settings, including the clamped one; polarity inversion in a running waveform; readback of staged versus active values across a real period boundary; and the address map with its 16-bit truncation.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int VAL_W    = 16;   // stored width of every channel value
  localparam int SEL_W    = 4;    // divider select field width
  localparam int SEL_MAX  = 10;   // largest divider exponent honoured
  localparam int POL_BIT  = 9;    // mode bit: output polarity
  localparam int ROUTE_BIT = 10;  // mode bit: target of the offset-0x10 update

  // global addresses
  localparam int A_START  = 'h04;
  localparam int A_STOP   = 'h08;
  localparam int A_RUN    = 'h0C;
  localparam int A_FLAGS  = 'h1C;

  // channel windows
  localparam int CH_BASE   = 'h200;
  localparam int CH_STRIDE = 'h20;

  // offsets inside a channel window
  localparam logic [4:0] O_MODE   = 5'h00;
  localparam logic [4:0] O_DUTY   = 5'h04;
  localparam logic [4:0] O_DUTY_U = 5'h08;
  localparam logic [4:0] O_PRD    = 5'h0C;
  localparam logic [4:0] O_PRD_U  = 5'h10;

  typedef struct packed {
    logic [VAL_W-1:0] mode;
    logic [VAL_W-1:0] duty;
    logic [VAL_W-1:0] duty_sh;
    logic [VAL_W-1:0] prd;
    logic [VAL_W-1:0] prd_sh;
  } chan_view_t;

  typedef struct packed {
    logic mode;
    logic duty;
    logic duty_u;
    logic prd;
    logic prd_u;
  } chan_wr_t;
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int SEL_W   = 4,
  parameter int SEL_MAX = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [SEL_MAX-1:0] div_q;
  logic [SEL_MAX-1:0] mask;
  int unsigned        eff;

  always_comb begin
    eff  = (int'(sel) > SEL_MAX) ? SEL_MAX : int'(sel);
    mask = {SEL_MAX{1'b1}} >> (SEL_MAX - eff);
    tick = run && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_quad_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  chan_wr_t         wr,
  input  logic [VAL_W-1:0] wval,
  output chan_view_t       view,
  output logic             wrap,
  output logic             pwm_o
);
  logic [VAL_W-1:0] mode_q, duty_q, duty_sh_q, prd_q, prd_sh_q, cnt_q, prd_eff;
  logic             pend_duty_q, pend_prd_q, out_q, tick;
  logic             stage_duty, stage_prd;

  pwm_tick_div #(.SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_div (
    .clk(clk), .rst(rst), .run(run), .sel(mode_q[SEL_W-1:0]), .tick(tick)
  );

  always_comb begin
    prd_eff    = (prd_q == '0) ? VAL_W'(1) : prd_q;
    wrap       = tick && (cnt_q >= prd_eff - 1'b1);
    stage_duty = wr.duty_u || (wr.prd_u && !mode_q[ROUTE_BIT]);
    stage_prd  = wr.prd_u && mode_q[ROUTE_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; duty_q <= '0; duty_sh_q <= '0; prd_q <= '0; prd_sh_q <= '0;
      pend_duty_q <= 1'b0; pend_prd_q <= 1'b0; cnt_q <= '0; out_q <= 1'b0;
    end else begin
      if (wr.mode) mode_q <= wval;
      if (!run && wr.duty) duty_q <= wval;
      if (!run && wr.prd)  prd_q  <= wval;
      // commit first, so a value staged in the wrap cycle stays pending
      if (wrap && pend_duty_q) begin duty_q <= duty_sh_q; pend_duty_q <= 1'b0; end
      if (wrap && pend_prd_q)  begin prd_q  <= prd_sh_q;  pend_prd_q  <= 1'b0; end
      if (stage_duty) begin duty_sh_q <= wval; pend_duty_q <= 1'b1; end
      if (stage_prd)  begin prd_sh_q  <= wval; pend_prd_q  <= 1'b1; end
      if (!run)      cnt_q <= '0;
      else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      out_q <= run ? ((cnt_q >= duty_q) ^ mode_q[POL_BIT]) : mode_q[POL_BIT];
    end
  end

  assign view  = '{mode: mode_q, duty: duty_q, duty_sh: duty_sh_q, prd: prd_q, prd_sh: prd_sh_q};
  assign pwm_o = out_q;

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    cnt_q < prd_eff); // R3
  AST_ACTIVE_HELD_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> ($stable(duty_q) && $stable(prd_q))); // R6
  AST_COMMIT_LOADS_STAGED: assert property (@(posedge clk) disable iff (rst)
    (wrap && pend_duty_q) |=> (duty_q == $past(duty_sh_q))); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_o == $past(mode_q[POL_BIT]))); // R5
endmodule

// File: rtl/pwm_quad_buffered.sv
module pwm_quad_buffered
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int IDX_W = ADDR_W - 5;
  localparam logic [ADDR_W-1:0] A_CH0  = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] A_CHE  = ADDR_W'(CH_BASE + NCH * CH_STRIDE);

  logic [NCH-1:0]    run_q, flag_q, wrap_v, ch_hit, start_bits, stop_bits;
  logic [ADDR_W-1:0] rel;
  logic [4:0]        off;
  logic              in_ch, rd_flags;
  logic [DATA_W-1:0] rd_val, rdata_q;
  chan_view_t        view [NCH];

  always_comb begin
    rel        = bus_addr - A_CH0;
    off        = bus_addr[4:0];
    in_ch      = (bus_addr >= A_CH0) && (bus_addr < A_CHE);
    start_bits = (bus_we && bus_addr == ADDR_W'(A_START)) ? bus_wdata[NCH-1:0] : '0;
    stop_bits  = (bus_we && bus_addr == ADDR_W'(A_STOP))  ? bus_wdata[NCH-1:0] : '0;
    rd_flags   = bus_re && (bus_addr == ADDR_W'(A_FLAGS));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_wr_t wr;
    assign ch_hit[i] = in_ch && (rel[ADDR_W-1:5] == IDX_W'(i));
    always_comb begin
      wr.mode   = bus_we && ch_hit[i] && off == O_MODE;
      wr.duty   = bus_we && ch_hit[i] && off == O_DUTY;
      wr.duty_u = bus_we && ch_hit[i] && off == O_DUTY_U;
      wr.prd    = bus_we && ch_hit[i] && off == O_PRD;
      wr.prd_u  = bus_we && ch_hit[i] && off == O_PRD_U;
    end
    pwm_chan u_chan (
      .clk(clk), .rst(rst), .run(run_q[i]), .wr(wr),
      .wval(bus_wdata[VAL_W-1:0]), .view(view[i]), .wrap(wrap_v[i]), .pwm_o(pwm_out[i])
    );
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(A_RUN))   rd_val[NCH-1:0] = run_q;
    if (bus_addr == ADDR_W'(A_FLAGS)) rd_val[NCH-1:0] = flag_q;
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) begin
        case (off)
          O_MODE:   rd_val = DATA_W'(view[i].mode);
          O_DUTY:   rd_val = DATA_W'(view[i].duty);
          O_DUTY_U: rd_val = DATA_W'(view[i].duty_sh);
          O_PRD:    rd_val = DATA_W'(view[i].prd);
          O_PRD_U:  rd_val = DATA_W'(view[i].prd_sh);
          default:  rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      flag_q  <= '0;
      rdata_q <= '0;
    end else begin
      run_q   <= (run_q | start_bits) & ~stop_bits;
      flag_q  <= (rd_flags ? '0 : flag_q) | wrap_v;
      rdata_q <= bus_re ? rd_val : '0;
    end
  end

  assign bus_rdata = rdata_q;

  AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(A_START))
      |=> ((run_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0]))); // R2
  AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(A_STOP))
      |=> ((run_q & $past(bus_wdata[NCH-1:0])) == '0)); // R2
  AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_flags && wrap_v == '0) |=> (flag_q == '0)); // R8
endmodule

// File: tb/pwm_quad_buffered_bench.sv
`timescale 1ns/1ps
module pwm_quad_buffered_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_quad_buffered u_pwm_quad_buffered (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic logic [9:0] ca(int ch, int o);
    return 10'('h200 + ch * 'h20 + o);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic highs(int ch, int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); if (pwm_out[ch]) h++; end
  endtask

  task automatic wait_flag(int ch, output bit seen);
    logic [31:0] v;
    seen = 0;
    for (int k = 0; k < 2000 && !seen; k++) begin
      rd(10'h1C, v);
      if (v[ch]) seen = 1;
    end
  endtask

  task automatic test_reset();
    logic [31:0] v;
    chk("R1", "outputs after reset", pwm_out, 0);
    rd(10'h0C, v); chk("R1", "run state", v, 0);
    rd(10'h1C, v); chk("R1", "flags", v, 0);
    rd(ca(2, 'h0C), v); chk("R1", "ch2 period", v, 0);
  endtask

  task automatic test_start_stop();
    logic [31:0] v;
    wr(10'h04, 32'h5); rd(10'h0C, v); chk("R2", "start 0101", v, 5);
    wr(10'h08, 32'h1); rd(10'h0C, v); chk("R2", "stop bit0", v, 4);
    wr(10'h08, 32'h4); rd(10'h0C, v); chk("R2", "stop bit2", v, 0);
  endtask

  task automatic test_waveform();
    logic [31:0] v; int h;
    wr(ca(0, 'h04), 3); wr(ca(0, 'h0C), 10);
    rd(ca(0, 'h04), v); chk("R6", "direct duty while stopped", v, 3);
    wr(10'h04, 32'h1); repeat (5) @(negedge clk);
    highs(0, 100, h); chk("R3", "duty3 period10 highs/100", h, 70);
    wr(ca(0, 'h04), 8); rd(ca(0, 'h04), v); chk("R6", "duty write ignored while running", v, 3);
    highs(0, 100, h); chk("R6", "waveform unchanged", h, 70);
    wr(10'h08, 32'h1);
  endtask

  task automatic test_divider();
    int h;
    wr(ca(1, 'h00), 2); wr(ca(1, 'h04), 1); wr(ca(1, 'h0C), 4);
    wr(10'h04, 32'h2); repeat (5) @(negedge clk);
    highs(1, 64, h); chk("R4", "sel2 highs/64", h, 48);
    wr(10'h08, 32'h2);
    wr(ca(1, 'h00), 15); wr(ca(1, 'h0C), 2);
    wr(10'h04, 32'h2); repeat (5) @(negedge clk);
    highs(1, 2048, h); chk("R4", "sel15 clamped highs/2048", h, 1024);
    wr(10'h08, 32'h2);
  endtask

  task automatic test_polarity();
    int h;
    wr(ca(2, 'h00), 32'h200); @(negedge clk);
    chk("R5", "stopped inverted level", pwm_out[2], 1);
    wr(ca(2, 'h04), 2); wr(ca(2, 'h0C), 8);
    wr(10'h04, 32'h4); repeat (5) @(negedge clk);
    highs(2, 80, h); chk("R5", "inverted highs/80", h, 20);
    wr(10'h08, 32'h4); @(negedge clk);
    chk("R5", "stopped returns to level", pwm_out[2], 1);
    chk("R5", "ch0 stopped low", pwm_out[0], 0);
    wr(ca(2, 'h00), 0);
  endtask

  task automatic test_edges();
    int h;
    wr(ca(3, 'h0C), 0); wr(ca(3, 'h04), 0);
    wr(10'h04, 32'h8); repeat (3) @(negedge clk);
    highs(3, 20, h); chk("R3", "period0 duty0 always high", h, 20);
    wr(10'h08, 32'h8);
    wr(ca(3, 'h0C), 4); wr(ca(3, 'h04), 5);
    wr(10'h04, 32'h8); repeat (3) @(negedge clk);
    highs(3, 40, h); chk("R3", "duty above period always low", h, 0);
    wr(10'h08, 32'h8);
  endtask

  task automatic test_regmap();
    logic [31:0] v;
    wr(ca(3, 'h00), 32'hABCD_1234); rd(ca(3, 'h00), v); chk("R9", "mode low16 only", v, 32'h1234);
    wr(ca(3, 'h00), 0);
    wr(ca(1, 'h04), 32'h0001_2345); rd(ca(1, 'h04), v); chk("R9", "duty low16 only", v, 32'h2345);
    rd(10'h100, v); chk("R9", "unmapped reads zero", v, 0);
  endtask

  task automatic test_update();
    logic [31:0] v; bit seen; int h;
    wr(ca(0, 'h00), 0); wr(ca(0, 'h04), 500); wr(ca(0, 'h0C), 1000);
    wr(10'h04, 32'h1); rd(10'h1C, v);
    wait_flag(0, seen); chk("R8", "wrap flag seen", seen, 1);
    rd(10'h1C, v); chk("R8", "flags cleared by read", v, 0);
    wr(ca(0, 'h08), 600);
    rd(ca(0, 'h04), v); chk("R7", "active duty before wrap", v, 500);
    rd(ca(0, 'h08), v); chk("R7", "staged duty readback", v, 600);
    wait_flag(0, seen); rd(ca(0, 'h04), v); chk("R7", "duty committed at wrap", v, 600);
    wr(ca(0, 'h00), 32'h400); wr(ca(0, 'h10), 200); wr(ca(0, 'h08), 50);
    rd(ca(0, 'h0C), v); chk("R7", "active period before wrap", v, 1000);
    wait_flag(0, seen);
    rd(ca(0, 'h0C), v); chk("R7", "period committed", v, 200);
    rd(ca(0, 'h04), v); chk("R7", "duty committed with period", v, 50);
    repeat (5) @(negedge clk);
    highs(0, 400, h); chk("R7", "new waveform highs/400", h, 300);
    wr(10'h08, 32'hF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_start_stop();
    test_waveform();
    test_divider();
    test_polarity();
    test_edges();
    test_regmap();
    test_update();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule